// File: doc/BRIEF.md
# Programmable SRAM Bus Cycle Generator

This block turns single-word read and write requests from the core side into asynchronous SRAM bus cycles for one memory area. The area is recognised from a 3-bit field at the top of the request address. Only when that field matches does the area's active-low chip select go low. Reads drive an active-low read strobe that can serve as output enable. Writes drive four active-low byte write strobes, and only the lanes whose byte enables are set are pulsed.

Each access is built from three phases. The first is an optional one-cycle address setup. The second is the strobe phase, which lasts one base cycle plus a programmed number of wait states. The third is a hold of zero to three cycles, during which the address and chip select stay valid. An external ready input can stretch the strobe phase further. The external data width can be set to 8, 16 or 32 bits. On a narrow bus, one request is split into several beats at ascending byte addresses, and each beat carries the full setup, wait and hold timing.

All timing and width settings are captured when a request is accepted. Changing them during an access has no effect on that access.

Top module: `sram_cycle_gen`

## Requirements
- R1: A request whose address bits [28:26] differ from AREA_CODE (default 3'b010) is accepted, and done_o pulses in the cycle after acceptance with rdata_o = 0. The chip select is never asserted for it. Bus chip select is asserted only while the bus address carries AREA_CODE in those bits.
- R2: When cfg_setup_i = 1, each beat begins with one cycle in which the chip select is low and no strobe is active. When cfg_setup_i = 0, the strobe starts in the first bus cycle.
- R3: cfg_wait_i codes 0..7 give 0, 1, 2, 3, 6, 9, 12 and 15 wait cycles. With ready high, the strobe of each beat is active for 1 + waits cycles.
- R4: After each strobe, the chip select and address stay valid for cfg_hold_i (0..3) more cycles. Each beat occupies setup + strobe + hold cycles of chip select.
- R5: bus_rdy_i is sampled only on the last wait cycle of a strobe. While it is low there, the strobe is extended one cycle at a time. A low level in earlier wait cycles does not lengthen the access.
- R6: A read drives bus_rd_n_o low and keeps every bus_we_n_o bit high. A write keeps bus_rd_n_o high and drives bus_we_n_o lanes low only for bytes whose req_be_i bit is set. The read strobe and the write strobes are never active together.
- R7: cfg_size_i = 2'b00 selects an 8-bit bus: 4 beats at word address + k, using data lane 0. 2'b01 selects a 16-bit bus: 2 beats at word address + 2k, using lanes 0..1. 2'b10 and 2'b11 select a 32-bit bus with a single beat. Read data is assembled little-endian: request byte k comes from byte address word + k.
- R8: req_ready_o is high only while idle. done_o is a one-cycle pulse in the cycle after the last chip-select cycle, so the latency from the accepting edge to done_o equals the total number of chip-select cycles plus one. rdata_o is valid while done_o is high.
- R9: The setup, wait, hold and size fields are sampled at acceptance. Changing them during an access does not alter that access.
- R10: While rst_ni is low, the chip select and all strobes are high, done_o is low, and the controller is idle with req_ready_o high. This holds even when reset arrives in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_setup_i | input | 1 | Setup cycles before the strobe (0 or 1) |
| cfg_wait_i | input | 3 | Encoded wait-state count |
| cfg_hold_i | input | 2 | Hold cycles after the strobe (0..3) |
| cfg_size_i | input | 2 | External bus width: 00 = 8, 01 = 16, 1x = 32 bits |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 29 | Byte address of the request; the word address is used |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte enables for writes |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | 32 | Assembled read data, valid with done_o |
| bus_addr_o | output | 29 | External address |
| bus_cs_n_o | output | 1 | Area chip select, active low |
| bus_rd_n_o | output | 1 | Read strobe / output enable, active low |
| bus_we_n_o | output | 4 | Byte write strobes, active low |
| bus_wdata_o | output | 32 | External write data |
| bus_rdata_i | input | 32 | External read data |
| bus_rdy_i | input | 1 | External ready; low stretches the strobe |

## Verification
The sharpest overlap sits on the last wait cycle of a strobe. In that one cycle, the ready sample, the capture of a beat's read data into its byte lanes, and the switch to hold or to the next beat all happen together. With zero setup and zero hold, that cycle leads straight into the next beat's strobe. The sweep drives every setup, wait and hold code against every width, so back-to-back beats with no gap are covered. The ready model is driven from the age of the strobe, which lets ready go low exactly on, or just before, the sampled cycle. Each outcome is judged on strobe length, chip-select length and latency computed from the field codes, and on read bytes that must match a pattern derived from the byte address.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = 8 * LANES;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phase_e;

  // codes 0..3 direct, 4..7 -> 6, 9, 12, 15
  function automatic logic [3:0] wait_cycles(logic [2:0] code);
    logic [4:0] c;
    c = {2'b00, code};
    if (code[2]) return 4'(c + c + c - 5'd6);
    return {1'b0, code};
  endfunction

  function automatic logic [1:0] beats_last(logic [1:0] size);
    case (size)
      2'b00:   return 2'd3;
      2'b01:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/sram_area_decode.sv
module sram_area_decode #(
  parameter int unsigned          AREA_W    = 3,
  parameter logic [AREA_W-1:0]    AREA_CODE = 3'b010
) (
  input  logic [AREA_W-1:0] area_i,
  output logic              hit_o
);
  assign hit_o = (area_i == AREA_CODE);
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_cyc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       skip_i,
  input  logic       setup_i,
  input  logic [2:0] wait_code_i,
  input  logic [1:0] hold_i,
  input  logic [1:0] size_i,
  input  logic       rdy_i,
  output phase_e     phase_o,
  output logic [1:0] beat_o,
  output logic [1:0] size_o,
  output logic       capture_o,
  output logic       idle_o
);
  phase_e     phase_q, phase_d;
  logic [3:0] cnt_q, cnt_d;
  logic [1:0] beat_q, beat_d;
  logic       setup_q;
  logic [3:0] wait_q;
  logic [1:0] hold_q, last_q, size_q;
  logic       beat_end;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    beat_d    = beat_q;
    capture_o = 1'b0;
    beat_end  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          beat_d = '0;
          if (setup_i) phase_d = PH_SETUP;
          else begin
            phase_d = PH_STROBE;
            cnt_d   = wait_cycles(wait_code_i);
          end
        end else if (skip_i) begin
          phase_d = PH_DONE;
        end
      end
      PH_SETUP: begin
        phase_d = PH_STROBE;
        cnt_d   = wait_q;
      end
      PH_STROBE: begin
        if (cnt_q != 4'd0) cnt_d = cnt_q - 4'd1;
        else if (rdy_i) begin
          capture_o = 1'b1;
          if (hold_q != 2'd0) begin
            phase_d = PH_HOLD;
            cnt_d   = {2'b00, hold_q} - 4'd1;
          end else beat_end = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q != 4'd0) cnt_d = cnt_q - 4'd1;
        else beat_end = 1'b1;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase

    if (beat_end) begin
      if (beat_q == last_q) phase_d = PH_DONE;
      else begin
        beat_d = beat_q + 2'd1;
        if (setup_q) phase_d = PH_SETUP;
        else begin
          phase_d = PH_STROBE;
          cnt_d   = wait_q;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      setup_q <= 1'b0;
      wait_q  <= '0;
      hold_q  <= '0;
      last_q  <= '0;
      size_q  <= 2'b10;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      if (phase_q == PH_IDLE && start_i) begin
        setup_q <= setup_i;
        wait_q  <= wait_cycles(wait_code_i);
        hold_q  <= hold_i;
        last_q  <= beats_last(size_i);
        size_q  <= size_i;
      end
    end
  end

  assign phase_o = phase_q;
  assign beat_o  = beat_q;
  assign size_o  = size_q;
  assign idle_o  = (phase_q == PH_IDLE);
endmodule

// File: rtl/sram_lane_mux.sv
module sram_lane_mux
  import sram_cyc_pkg::*;
#(
  parameter int unsigned ADDR_W = 29
) (
  input  logic [1:0]        size_i,
  input  logic [1:0]        beat_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic [DATA_W-1:0] merge_o
);
  always_comb begin
    unique case (size_i)
      2'b00: begin
        addr_o    = base_i + {{(ADDR_W-2){1'b0}}, beat_i};
        wdata_o   = {LANES{wdata_i[{beat_i, 3'b000} +: 8]}};
        lane_we_o = {{(LANES-1){1'b0}}, be_i[beat_i]};
      end
      2'b01: begin
        addr_o    = base_i + {{(ADDR_W-2){1'b0}}, beat_i[0], 1'b0};
        wdata_o   = {(LANES/2){wdata_i[{beat_i[0], 4'b0000} +: 16]}};
        lane_we_o = {{(LANES-2){1'b0}}, be_i[{beat_i[0], 1'b0} +: 2]};
      end
      default: begin
        addr_o    = base_i;
        wdata_o   = wdata_i;
        lane_we_o = be_i;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] b;
    always_comb begin
      unique case (size_i)
        2'b00:   b = (beat_i == 2'(g)) ? rdata_i[7:0] : acc_i[8*g +: 8];
        2'b01:   b = (beat_i[0] == 1'(g / 2)) ? rdata_i[8*(g%2) +: 8] : acc_i[8*g +: 8];
        default: b = rdata_i[8*g +: 8];
      endcase
    end
    assign merge_o[8*g +: 8] = b;
  end
endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
  import sram_cyc_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 29,
  parameter int unsigned       AREA_W    = 3,
  parameter logic [AREA_W-1:0] AREA_CODE = 3'b010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_setup_i,
  input  logic [2:0]        cfg_wait_i,
  input  logic [1:0]        cfg_hold_i,
  input  logic [1:0]        cfg_size_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_cs_n_o,
  output logic              bus_rd_n_o,
  output logic [LANES-1:0]  bus_we_n_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rdy_i
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(LANES - 1);

  phase_e            phase;
  logic [1:0]        beat, size_q;
  logic              capture, idle, hit, accept;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, merge;
  logic [LANES-1:0]  be_q, lane_we;
  logic              strobe;

  sram_area_decode #(.AREA_W(AREA_W), .AREA_CODE(AREA_CODE)) u_dec (
    .area_i (req_addr_i[ADDR_W-1 -: AREA_W]),
    .hit_o  (hit)
  );

  assign accept = req_valid_i & idle;

  sram_cycle_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept & hit),
    .skip_i      (accept & ~hit),
    .setup_i     (cfg_setup_i),
    .wait_code_i (cfg_wait_i),
    .hold_i      (cfg_hold_i),
    .size_i      (cfg_size_i),
    .rdy_i       (bus_rdy_i),
    .phase_o     (phase),
    .beat_o      (beat),
    .size_o      (size_q),
    .capture_o   (capture),
    .idle_o      (idle)
  );

  sram_lane_mux #(.ADDR_W(ADDR_W)) u_mux (
    .size_i    (size_q),
    .beat_i    (beat),
    .base_i    (addr_q),
    .wdata_i   (wdata_q),
    .be_i      (be_q),
    .rdata_i   (bus_rdata_i),
    .acc_i     (rdata_q),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o),
    .lane_we_o (lane_we),
    .merge_o   (merge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write_i;
      addr_q  <= req_addr_i & WORD_MASK;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= merge;
    end
  end

  assign strobe      = (phase == PH_STROBE);
  assign bus_cs_n_o  = !(phase inside {PH_SETUP, PH_STROBE, PH_HOLD});
  assign bus_rd_n_o  = !(strobe && !write_q);
  assign bus_we_n_o  = ~(lane_we & {LANES{strobe && write_q}});
  assign req_ready_o = idle;
  assign done_o      = (phase == PH_DONE);
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/sram_cycle_gen_chk.sv
module sram_cycle_gen_chk #(
  parameter int unsigned       AREA_W    = 3,
  parameter logic [AREA_W-1:0] AREA_CODE = 3'b010
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              bus_cs_n_o,
  input logic              bus_rd_n_o,
  input logic [3:0]        bus_we_n_o,
  input logic [AREA_W-1:0] area_i
);
  assert_strobe_in_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_n_o || !(&bus_we_n_o)) |-> !bus_cs_n_o);

  assert_rd_we_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_n_o |-> (&bus_we_n_o));

  assert_cs_area_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_cs_n_o |-> (area_i == AREA_CODE));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_cs_n_o && !req_ready_o));

  assert_busy_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind sram_cycle_gen sram_cycle_gen_chk #(.AREA_W(AREA_W), .AREA_CODE(AREA_CODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .bus_cs_n_o  (bus_cs_n_o),
  .bus_rd_n_o  (bus_rd_n_o),
  .bus_we_n_o  (bus_we_n_o),
  .area_i      (bus_addr_o[ADDR_W-1 -: AREA_W])
);

// File: tb/sram_cycle_gen_tb_top.sv
module sram_cycle_gen_tb_top;
  localparam int ADDR_W = 29;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_setup_i = 1'b0;
  logic [2:0]        cfg_wait_i = '0;
  logic [1:0]        cfg_hold_i = '0;
  logic [1:0]        cfg_size_i = 2'b10;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic              req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [31:0]       req_wdata_i = '0;
  logic [3:0]        req_be_i = '0;
  logic              done_o;
  logic [31:0]       rdata_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic              bus_cs_n_o, bus_rd_n_o;
  logic [3:0]        bus_we_n_o;
  logic [31:0]       bus_wdata_o;
  logic [31:0]       bus_rdata_i;
  logic              bus_rdy_i;

  int errors = 0;
  int checks = 0;
  int stall = 0;
  int age = 0;

  logic [7:0] sh_val [64];
  bit         sh_flag[64];
  int         sh_cnt [64];

  always #4 clk_i = ~clk_i;

  sram_cycle_gen dut_i (.*);

  function automatic logic [7:0] pat(int a);
    return 8'((a % 64) * 29 + 90);
  endfunction

  always_comb
    for (int j = 0; j < 4; j++) bus_rdata_i[8*j +: 8] = pat(int'(bus_addr_o[5:0]) + j);

  // ready rises once the strobe has been active for 'stall' cycles
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) age <= 0;
    else if (!bus_rd_n_o || !(&bus_we_n_o)) age <= age + 1;
    else age <= 0;
  assign bus_rdy_i = (age >= stall);

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                        input logic [3:0] be, input bit s, input logic [2:0] w,
                        input logic [1:0] h, input logic [1:0] sz, input bit chg,
                        output int lat, output int cs_cnt, output int stb_cnt,
                        output int first_stb, output bit rd_seen, output logic [31:0] rd);
    for (int i = 0; i < 64; i++) begin sh_flag[i] = 0; sh_val[i] = '0; sh_cnt[i] = 0; end
    @(negedge clk_i);
    cfg_setup_i = s; cfg_wait_i = w; cfg_hold_i = h; cfg_size_i = sz;
    req_write_i = wr; req_addr_i = addr; req_wdata_i = wd; req_be_i = be; req_valid_i = 1'b1;
    check(req_ready_o == 1'b1, "R8", "ready while idle", 32'(req_ready_o), 1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (chg) begin
      cfg_setup_i = ~s; cfg_wait_i = ~w; cfg_hold_i = ~h; cfg_size_i = ~sz;
    end
    check(req_ready_o == 1'b0, "R8", "ready while busy", 32'(req_ready_o), 0);
    lat = 1; cs_cnt = 0; stb_cnt = 0; first_stb = 0; rd_seen = 0;
    while (!done_o) begin
      if (!bus_cs_n_o) cs_cnt++;
      if (!bus_rd_n_o) begin
        rd_seen = 1; stb_cnt++;
        if (first_stb == 0) first_stb = lat;
      end
      for (int j = 0; j < 4; j++)
        if (!bus_we_n_o[j]) begin
          int idx;
          idx = (int'(bus_addr_o[5:0]) + j) % 64;
          sh_flag[idx] = 1;
          sh_val[idx]  = bus_wdata_o[8*j +: 8];
          sh_cnt[idx]++;
        end
      @(negedge clk_i);
      lat++;
    end
    rd = rdata_o;
  endtask

  task automatic run_and_check(input bit wr, input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                               input logic [3:0] be, input bit s, input logic [2:0] w,
                               input logic [1:0] h, input logic [1:0] sz, input bit chg);
    int beats, wt, stb, c, lat, cs_cnt, stb_cnt, first_stb;
    bit rd_seen;
    logic [31:0] rd, exp;
    beats = (sz == 2'b00) ? 4 : (sz == 2'b01) ? 2 : 1;
    wt    = (w < 4) ? int'(w) : 3 * int'(w) - 6;
    stb   = ((stall > wt) ? stall : wt) + 1;
    c     = beats * (int'(s) + stb + int'(h));
    access(wr, addr, wd, be, s, w, h, sz, chg, lat, cs_cnt, stb_cnt, first_stb, rd_seen, rd);
    check(lat == c + 1, "R8", "latency to done", 32'(lat), 32'(c + 1));
    check(cs_cnt == c, "R4", "chip select cycles", 32'(cs_cnt), 32'(c));
    if (!wr) begin
      check(stb_cnt == beats * stb, "R3", "read strobe cycles", 32'(stb_cnt), 32'(beats * stb));
      check(first_stb == int'(s) + 1, "R2", "first strobe cycle", 32'(first_stb), 32'(int'(s) + 1));
      for (int k = 0; k < 4; k++) exp[8*k +: 8] = pat(int'(addr[5:0]) + k);
      check(rd == exp, "R7", "assembled read data", rd, exp);
    end else begin
      check(!rd_seen, "R6", "no read strobe on write", 32'(rd_seen), 0);
      for (int k = 0; k < 4; k++) begin
        int idx;
        idx = (int'(addr[5:0]) + k) % 64;
        if (be[k]) begin
          check(sh_flag[idx] && sh_val[idx] == wd[8*k +: 8], "R7", "written byte",
                {24'h0, sh_val[idx]}, {24'h0, wd[8*k +: 8]});
          check(sh_cnt[idx] == stb, "R6", "write strobe length", 32'(sh_cnt[idx]), 32'(stb));
        end else begin
          check(!sh_flag[idx], "R6", "disabled byte untouched", 32'(sh_flag[idx]), 0);
        end
      end
    end
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_sim();
  end

  initial begin
    int lat, cs_cnt, stb_cnt, first_stb, idx;
    bit rd_seen;
    logic [31:0] rd;

    // R10 reset state
    repeat (3) @(negedge clk_i);
    check(bus_cs_n_o && bus_rd_n_o && (&bus_we_n_o), "R10", "strobes high in reset",
          {28'h0, bus_we_n_o}, 32'hF);
    check(req_ready_o && !done_o, "R10", "idle in reset", {30'h0, req_ready_o, done_o}, 32'h2);
    rst_ni = 1'b1;

    // sweep of every timing code against every width and direction
    idx = 0;
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 8; w++)
        for (int h = 0; h < 4; h++)
          for (int sz = 0; sz < 3; sz++)
            for (int wr = 0; wr < 2; wr++) begin
              run_and_check(wr[0], 29'h0800_0000 | 29'((idx * 4) & 'h3C),
                            32'h1234_5678 ^ 32'(idx * 32'h9E37_79B9), 4'(idx),
                            s[0], 3'(w), 2'(h), 2'(sz), 1'b0);
              idx++;
            end

    // R9 configuration changed right after acceptance
    run_and_check(1'b0, 29'h0800_0024, 32'h0, 4'h0, 1'b0, 3'd1, 2'd1, 2'b00, 1'b1);
    run_and_check(1'b1, 29'h0800_0028, 32'hCAFE_F00D, 4'hB, 1'b1, 3'd5, 2'd0, 2'b01, 1'b1);

    // R5 ready stretching and ready low before the sampled cycle
    stall = 6;
    run_and_check(1'b0, 29'h0800_0030, 32'h0, 4'h0, 1'b1, 3'd2, 2'd1, 2'b10, 1'b0);
    run_and_check(1'b1, 29'h0800_0034, 32'h89AB_CDEF, 4'hF, 1'b0, 3'd0, 2'd2, 2'b10, 1'b0);
    stall = 2;
    run_and_check(1'b0, 29'h0800_0038, 32'h0, 4'h0, 1'b0, 3'd2, 2'd0, 2'b10, 1'b0);
    stall = 0;

    // R1 request outside the area
    access(1'b0, 29'h0C00_0040, 32'h0, 4'h0, 1'b1, 3'd3, 2'd3, 2'b00, 1'b0,
           lat, cs_cnt, stb_cnt, first_stb, rd_seen, rd);
    check(lat == 1, "R1", "miss latency", 32'(lat), 1);
    check(cs_cnt == 0 && stb_cnt == 0, "R1", "miss chip select", 32'(cs_cnt), 0);
    check(rd == 32'h0, "R1", "miss read data", rd, 0);
    access(1'b1, 29'h1000_0004, 32'hFFFF_FFFF, 4'hF, 1'b0, 3'd0, 2'd0, 2'b10, 1'b0,
           lat, cs_cnt, stb_cnt, first_stb, rd_seen, rd);
    check(lat == 1 && cs_cnt == 0, "R1", "write miss no cycle", 32'(cs_cnt), 0);
    check(!sh_flag[4], "R1", "write miss no strobe", 32'(sh_flag[4]), 0);

    // R10 reset in the middle of an access
    @(negedge clk_i);
    cfg_setup_i = 1'b1; cfg_wait_i = 3'd7; cfg_hold_i = 2'd3; cfg_size_i = 2'b00;
    req_write_i = 1'b1; req_addr_i = 29'h0800_0000; req_be_i = 4'hF; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check(!bus_cs_n_o, "R10", "access in flight", 32'(bus_cs_n_o), 0);
    rst_ni = 1'b0;
    #1;
    check(bus_cs_n_o && bus_rd_n_o && (&bus_we_n_o), "R10", "strobes released by reset",
          {27'h0, bus_cs_n_o, bus_we_n_o}, 32'h1F);
    check(req_ready_o && !done_o, "R10", "idle after reset", {30'h0, req_ready_o, done_o}, 32'h2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_and_check(1'b0, 29'h0800_003C, 32'h0, 4'h0, 1'b0, 3'd4, 2'd1, 2'b01, 1'b0);

    finish_sim();
  end
endmodule